// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error Flags

This block receives asynchronous serial characters on a single input line and presents them to a host through a small register port. A sample tick from an external rate generator marks sixteen sample points per bit period. Each bit is resolved by a majority vote over three samples in the middle of the bit. A finished character, with 8 or 9 data bits, is moved from the shift register into a holding data register. The ninth bit, when present, goes to a separate control register bit.

A status register reports that data is ready, and it reports three error conditions. Overrun means a character arrived while the holding register was still full. Noise means a vote was not unanimous on some bit of the character. Framing means the stop bit was sampled low. The host clears flags with two accesses in a row: a status read, then a data read. Only the flags that were set when the status was read are cleared. Any other access between the two breaks the sequence.

Register map (2-bit address): 0 = status, read only. 1 = data, read only; writes are ignored. 2 = control: bit 4 is the 9-bit mode, read/write; bit 7 is the received ninth bit, read only. Status bits: 7 = ready, 3 = overrun, 2 = noise, 1 = framing. All other bits read as 0.

Top module: `uart_rx_flags`

## Requirements
- R1: After reset, status, data and control all read 0x00.
- R2: A character is received LSB first, with one start bit, 8 data bits and one stop bit, at 16 ticks per bit. When it completes, status bit 7 (ready) sets and address 1 returns the byte.
- R3: Each bit takes the majority of samples 7, 8 and 9 of its period. One disagreeing sample, on any bit including the start bit, still gives the correct value and sets status bit 2 (noise) together with ready.
- R4: A low pulse on the idle line whose voting samples are mostly high is a false start. It leaves ready clear, and the receiver then accepts the next valid character.
- R5: A stop bit whose vote is low sets status bit 1 (framing) in the same update that sets ready.
- R6: A character that completes while ready is set sets status bit 3 (overrun) and is discarded. The data register keeps its previous byte.
- R7: A character that has both a framing error and an overrun reports only overrun. Framing stays clear.
- R8: While framing is set, no new character enters the data register.
- R9: A status read followed directly by a data read clears exactly the flags that were set at the status read. A flag set after the status read remains set.
- R10: Any other register access between the status read and the data read cancels the clear. All flags keep their values.
- R11: Control bit 4 selects 9 data bits. In that mode the ninth received bit is returned in control bit 7 and the low 8 bits at address 1.
- R12: The noise flag is never set while ready is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Sample tick, 16 per bit period |
| rxd_i | input | 1 | Serial receive line, idle high |
| reg_addr_i | input | 2 | Register address |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data (combinational from address) |

## Verification
The bench uses the default values: 16 samples per bit and 8 data bits. This places the voting samples at positions 7 to 9, so one corrupted sample can be placed just inside the vote window or just outside the start qualification. The tick is asserted on every second clock, which exercises tick gating between samples. The 9-bit setting comes from the control register at run time, so one build covers both character lengths. It also covers the overrun, framing and clear-sequence interactions.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_state_e;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_DATA   = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;

  localparam int ST_READY = 7;
  localparam int ST_OVR   = 3;
  localparam int ST_NOISE = 2;
  localparam int ST_FRAME = 1;
  localparam int CT_BIT8  = 7;
  localparam int CT_NINE  = 4;
endpackage

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              nine_i,
  output logic              done_o,
  output logic [DATA_W:0]   frame_o,
  output logic              noise_o,
  output logic              ferr_o
);
  localparam int PH_W  = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam logic [PH_W-1:0] V0   = PH_W'(OSR / 2 - 2);
  localparam logic [PH_W-1:0] V1   = PH_W'(OSR / 2 - 1);
  localparam logic [PH_W-1:0] V2   = PH_W'(OSR / 2);
  localparam logic [PH_W-1:0] PEND = PH_W'(OSR - 1);

  rx_state_e         state_q;
  logic [PH_W-1:0]   ph_q;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        vq;
  logic              prev_q, nine_q, nz_q;
  logic [DATA_W:0]   sh_q;
  logic              vote, noisy, at_vote, last_bit;

  assign vote     = (vq[0] & vq[1]) | (vq[0] & rxd_i) | (vq[1] & rxd_i);
  assign noisy    = !((vq[0] == vq[1]) && (vq[1] == rxd_i));
  assign at_vote  = tick_i && (state_q != S_IDLE) && (ph_q == V2);
  assign last_bit = idx_q == (nine_q ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ph_q    <= '0;
      idx_q   <= '0;
      vq      <= '0;
      prev_q  <= 1'b1;
      nine_q  <= 1'b0;
      nz_q    <= 1'b0;
      sh_q    <= '0;
      done_o  <= 1'b0;
      frame_o <= '0;
      noise_o <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        prev_q <= rxd_i;
        if (state_q == S_IDLE) begin
          if (prev_q && !rxd_i) begin
            state_q <= S_START;
            ph_q    <= '0;
            idx_q   <= '0;
            nz_q    <= 1'b0;
            sh_q    <= '0;
            nine_q  <= nine_i;
          end
        end else begin
          ph_q <= (ph_q == PEND) ? '0 : ph_q + 1'b1;
          if (ph_q == V0) vq[0] <= rxd_i;
          if (ph_q == V1) vq[1] <= rxd_i;
          if (ph_q == V2) begin
            unique case (state_q)
              S_START: begin
                if (vote) state_q <= S_IDLE;  // false start
                else nz_q <= noisy;
              end
              S_DATA: begin
                sh_q[idx_q] <= vote;
                nz_q        <= nz_q | noisy;
              end
              S_STOP: begin
                done_o  <= 1'b1;
                frame_o <= sh_q;
                noise_o <= nz_q | noisy;
                ferr_o  <= !vote;
                state_q <= S_IDLE;
              end
              default: ;
            endcase
          end
          if (ph_q == PEND) begin
            if (state_q == S_START) state_q <= S_DATA;
            else if (state_q == S_DATA) begin
              if (last_bit) state_q <= S_STOP;
              else idx_q <= idx_q + 1'b1;
            end
          end
        end
      end
    end
  end

  assert_false_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_vote && state_q == S_START && vote) |=> (state_q == S_IDLE && !done_o));
  assert_done_from_stop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(state_q) == S_STOP && state_q == S_IDLE));
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W:0]   frame_i,
  input  logic              noise_i,
  input  logic              ferr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              nine_o
);
  logic              rdy_q, ovr_q, nf_q, fe_q, bit8_q, mode_q, armed_q;
  logic [3:0]        snap_q, clr;
  logic [DATA_W-1:0] data_q;
  logic              rdy_d, ovr_d, nf_d, fe_d, load;
  logic              st_rd, dt_rd, any_acc;

  assign st_rd   = reg_rd_i && reg_addr_i == ADDR_STATUS;
  assign dt_rd   = reg_rd_i && reg_addr_i == ADDR_DATA;
  assign any_acc = reg_rd_i || reg_wr_i;
  assign clr     = (dt_rd && armed_q) ? snap_q : 4'b0;
  assign load    = done_i && !rdy_q && !fe_q;
  assign nine_o  = mode_q;

  always_comb begin
    rdy_d = rdy_q & ~clr[3];
    ovr_d = ovr_q & ~clr[2];
    nf_d  = nf_q  & ~clr[1];
    fe_d  = fe_q  & ~clr[0];
    if (done_i && rdy_q) ovr_d = 1'b1;  // overrun wins over framing
    if (load) begin
      rdy_d = 1'b1;
      nf_d  = noise_i;
      fe_d  = ferr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q   <= 1'b0;
      ovr_q   <= 1'b0;
      nf_q    <= 1'b0;
      fe_q    <= 1'b0;
      bit8_q  <= 1'b0;
      mode_q  <= 1'b0;
      armed_q <= 1'b0;
      snap_q  <= '0;
      data_q  <= '0;
    end else begin
      rdy_q <= rdy_d;
      ovr_q <= ovr_d;
      nf_q  <= nf_d;
      fe_q  <= fe_d;
      if (load) begin
        data_q <= frame_i[DATA_W-1:0];
        bit8_q <= frame_i[DATA_W];
      end
      if (st_rd) begin
        armed_q <= 1'b1;
        snap_q  <= {rdy_q, ovr_q, nf_q, fe_q};
      end else if (any_acc) armed_q <= 1'b0;
      if (reg_wr_i && reg_addr_i == ADDR_CTRL) mode_q <= reg_wdata_i[CT_NINE];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_STATUS: begin
        reg_rdata_o[ST_READY] = rdy_q;
        reg_rdata_o[ST_OVR]   = ovr_q;
        reg_rdata_o[ST_NOISE] = nf_q;
        reg_rdata_o[ST_FRAME] = fe_q;
      end
      ADDR_DATA: reg_rdata_o[DATA_W-1:0] = data_q;
      ADDR_CTRL: begin
        reg_rdata_o[CT_BIT8] = bit8_q;
        reg_rdata_o[CT_NINE] = mode_q;
      end
      default: ;
    endcase
  end

  assert_ovr_on_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && rdy_q) |=> (ovr_q && $stable(data_q)));
  assert_ovr_hides_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && rdy_q && !fe_q) |=> !fe_q);
  assert_frame_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && fe_q) |=> $stable(data_q));
  assert_noise_with_ready_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nf_q |-> rdy_q);
  assert_disarm_keeps_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dt_rd && !armed_q && !done_i) |=> $stable({rdy_q, ovr_q, nf_q, fe_q}));
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import uart_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic [1:0] reg_addr_i,
  input  logic       reg_rd_i,
  input  logic       reg_wr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o
);
  logic              done, noise, ferr, nine;
  logic [DATA_W:0]   frame;

  uart_rx_core #(.OSR(OSR), .DATA_W(DATA_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .rxd_i   (rxd_i),
    .nine_i  (nine),
    .done_o  (done),
    .frame_o (frame),
    .noise_o (noise),
    .ferr_o  (ferr)
  );

  uart_rx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (done),
    .frame_i     (frame),
    .noise_i     (noise),
    .ferr_i      (ferr),
    .reg_addr_i  (reg_addr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .nine_o      (nine)
  );
endmodule

// File: tb/uart_rx_flags_test.sv
module uart_rx_flags_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int checks = 0, errors = 0;

  typedef struct { logic [7:0] st; logic [7:0] dt; string tag; } exp_t;
  exp_t exp_q[$];
  logic line_q[$];

  uart_rx_flags uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd),
    .reg_addr_i(addr), .reg_rd_i(rd), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  always #5 clk = ~clk;

  // tick every second clock; line advances one sample per tick
  always @(negedge clk) begin
    tick <= ~tick;
    if (!tick) rxd <= (line_q.size() > 0) ? line_q.pop_front() : 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_read(logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic reg_write(logic [1:0] a, logic [7:0] v);
    @(negedge clk);
    addr = a; wdata = v; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  // nb data bits; stop level; one sample (1..16) of bit nbit flipped when nbit >= 0
  task automatic send(logic [8:0] d, int nb, logic stop_v, int nbit, int nsamp);
    for (int b = 0; b < nb + 2; b++) begin
      logic v;
      v = (b == 0) ? 1'b0 : (b == nb + 1) ? stop_v : d[b-1];
      for (int s = 1; s <= 16; s++) line_q.push_back((b == nbit && s == nsamp) ? ~v : v);
    end
    for (int s = 0; s < 16; s++) line_q.push_back(1'b1);
    while (line_q.size() > 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_item(logic [7:0] st, logic [7:0] dt, string tag);
    exp_t e;
    e.st = st; e.dt = dt; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: pops expectation, reads status then data (which also clears)
  task automatic drain_one();
    exp_t e;
    logic [7:0] v;
    e = exp_q.pop_front();
    reg_read(2'd0, v); chk({e.tag, " status"}, v, e.st);
    reg_read(2'd1, v); chk({e.tag, " data"}, v, e.dt);
  endtask

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    reg_read(2'd0, v); chk("R1 status", v, 8'h00);
    reg_read(2'd1, v); chk("R1 data", v, 8'h00);
    reg_read(2'd2, v); chk("R1 ctrl", v, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    send(9'h0A5, 8, 1'b1, -1, 0);
    expect_item(8'h80, 8'hA5, "R2 clean frame"); drain_one();
    reg_read(2'd0, v); chk("R9 cleared after seq", v, 8'h00);

    send(9'h03C, 8, 1'b1, 4, 8);
    expect_item(8'h84, 8'h3C, "R3 noise data bit"); drain_one();
    send(9'h0C3, 8, 1'b1, 0, 8);
    expect_item(8'h84, 8'hC3, "R3 noise start bit"); drain_one();
    send(9'h081, 8, 1'b1, 9, 9);
    expect_item(8'h84, 8'h81, "R3 noise stop bit"); drain_one();
    reg_read(2'd0, v); chk("R12 noise cleared with ready", v, 8'h00);

    for (int s = 0; s < 3; s++) line_q.push_back(1'b0);
    for (int s = 0; s < 40; s++) line_q.push_back(1'b1);
    while (line_q.size() > 0) @(negedge clk);
    repeat (6) @(negedge clk);
    reg_read(2'd0, v); chk("R4 false start no ready", v, 8'h00);
    send(9'h066, 8, 1'b1, -1, 0);
    expect_item(8'h80, 8'h66, "R4 frame after false start"); drain_one();

    send(9'h0F0, 8, 1'b0, -1, 0);
    expect_item(8'h82, 8'hF0, "R5 framing with ready"); drain_one();

    send(9'h011, 8, 1'b1, -1, 0);
    send(9'h022, 8, 1'b1, -1, 0);
    expect_item(8'h88, 8'h11, "R6 overrun keeps old byte"); drain_one();

    send(9'h05A, 8, 1'b1, -1, 0);
    send(9'h0FF, 8, 1'b0, -1, 0);
    expect_item(8'h88, 8'h5A, "R7 overrun hides framing"); drain_one();

    send(9'h0E1, 8, 1'b0, -1, 0);
    send(9'h01E, 8, 1'b1, -1, 0);
    expect_item(8'h8A, 8'hE1, "R8 framing blocks load"); drain_one();
    reg_read(2'd0, v); chk("R8 all cleared", v, 8'h00);

    send(9'h033, 8, 1'b1, -1, 0);
    reg_read(2'd0, v); chk("R9 status before late flag", v, 8'h80);
    send(9'h044, 8, 1'b1, -1, 0);
    reg_read(2'd1, v); chk("R9 data", v, 8'h33);
    reg_read(2'd0, v); chk("R9 late overrun kept", v, 8'h08);
    reg_read(2'd1, v);
    reg_read(2'd0, v); chk("R9 overrun cleared", v, 8'h00);

    send(9'h055, 8, 1'b1, -1, 0);
    reg_read(2'd0, v);
    reg_read(2'd2, v);
    reg_read(2'd1, v); chk("R10 data read", v, 8'h55);
    reg_read(2'd0, v); chk("R10 ready kept after break", v, 8'h80);
    reg_write(2'd1, 8'h00);
    reg_read(2'd1, v);
    reg_read(2'd0, v); chk("R10 write breaks seq", v, 8'h80);
    reg_read(2'd1, v);
    reg_read(2'd0, v); chk("R10 clean seq clears", v, 8'h00);

    reg_write(2'd2, 8'h10);
    reg_read(2'd2, v); chk("R11 mode set", v, 8'h10);
    send(9'h13C, 9, 1'b1, -1, 0);
    reg_read(2'd2, v); chk("R11 ninth bit one", v, 8'h90);
    expect_item(8'h80, 8'h3C, "R11 low byte"); drain_one();
    send(9'h0C3, 9, 1'b1, -1, 0);
    reg_read(2'd2, v); chk("R11 ninth bit zero", v, 8'h10);
    expect_item(8'h80, 8'hC3, "R11 low byte 2"); drain_one();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule